// File: doc/BRIEF.md
# ECC-Protected SRAM Bank with Test-Mode Write Gating

This block holds four small single-port memory banks. Each word is 32 data bits plus 7 SEC-DED check bits. On a write, a shared encoder computes the check bits. A 2-bit mode per bank decides which part of the stored word is actually updated. Software can therefore write data without touching its check bits, or write check bits taken straight from the write port without touching the data. This lets it plant single-bit and double-bit errors on purpose and watch the read path catch them.

On a read, the selected bank returns its raw word one cycle after the request. A shared decoder then corrects a single flipped bit, or flags a word it cannot repair. The raw stored check bits are also returned, so the effect of each write mode can be observed directly.

A single 32-bit control word holds the four mode fields. Its upper bits are tied to zero.

Top module: `ecc_tm_top`

## Requirements
- R1: In mode 00, a write stores both the write data and its encoded check bits. A later read returns the same data and those check bits, with both error flags low.
- R2: In mode 01, a write stores the data bits only. The check bits stored at that address stay as they were.
- R3: In mode 10, a write stores `mem_wchk` as the check bits and leaves the stored data bits unchanged. The encoder output is not used.
- R4: Mode 11 behaves exactly like mode 00, and `mem_wchk` is ignored.
- R5: The control word holds the mode of bank n in bits 2n+1:2n (bank 0 in 1:0, bank 3 in 7:6). Bits 31:8 read as zero whatever is written. Each field governs only its own bank.
- R6: Synchronous active-low reset sets every mode field to 00, so `cfg_rdata` reads 0, and drives `rd_valid` low.
- R7: Check-bit code: data bit j sits at the j-th position, counting from 1, that is not a power of two (bit 0 at position 3). Check bit i (0..5) is the XOR of the data bits whose position has bit i set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5.
- R8: A read of a word with exactly one flipped bit, in data or in check bits, returns corrected data with `rd_err_single` high and `rd_err_double` low.
- R9: A read of a word with two flipped bits raises `rd_err_double` with `rd_err_single` low. The two flags are never high together, and both are low when `rd_valid` is low.
- R10: A read request gives `rd_valid` high in the following cycle, with data, check bits and flags valid in that same cycle. A write or an idle cycle gives `rd_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word read value |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_bank | input | 2 | Bank select |
| mem_addr | input | ADDR_W | Word address within bank |
| mem_wdata | input | 32 | Write data |
| mem_wchk | input | 7 | Check bits written in mode 10 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Corrected read data |
| rd_chk | output | 7 | Raw stored check bits of the read word |
| rd_err_single | output | 1 | Single-bit error corrected |
| rd_err_double | output | 1 | Uncorrectable error detected |

## Verification
Functional writes are exercised with all-zero, all-one, alternating and single-high-bit data. These patterns separate a correct code from one with a misplaced data position or a wrong parity group. Data-only writes that differ from the old word in one bit and in two bits show that the old check bits were kept, and that correction and double detection both work. Check-only writes flip a low check bit, the overall parity bit, or two check bits, which tells errors in the syndrome bits apart from errors in the overall bit. Per-bank mode settings and a mid-run reset show that the fields are isolated from one another and that they clear.

// File: rtl/ecc_tm_pkg.sv
// Package: shared types and SEC-DED code helpers for the ECC test-mode banks.
// Assumes 32 data bits, 6 Hamming bits and one overall parity bit.
package ecc_tm_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CHK_W  = HAM_W + 1;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        TM_FUNC      = 2'b00,
        TM_DATA_ONLY = 2'b01,
        TM_CHK_ONLY  = 2'b10,
        TM_FUNC_ALT  = 2'b11
    } tm_mode_e;

    // True when v is a power of two (v > 0).
    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Codeword position of data bit j: the j-th non-power-of-two from 3 upward.
    function automatic int unsigned data_pos(input int unsigned j);
        int unsigned cnt;
        int unsigned res;
        cnt = 0;
        res = 0;
        for (int unsigned p = 3; p < 64; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Hamming parity bits over the data word.
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        h = '0;
        for (int j = 0; j < DATA_W; j++) begin
            for (int i = 0; i < HAM_W; i++) begin
                if (data_pos(j)[i]) h[i] = h[i] ^ d[j];
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/ecc_tm_encoder.sv
// Module: SEC-DED check-bit generator.
// Produces 6 Hamming bits plus an overall parity bit; purely combinational.
module ecc_tm_encoder
    import ecc_tm_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [HAM_W-1:0] ham;

    // Compute Hamming bits and overall parity over data and Hamming bits.
    always_comb begin
        ham   = ham_bits(data_i);
        chk_o = {(^data_i) ^ (^ham), ham};
    end

endmodule

// File: rtl/ecc_tm_decoder.sv
// Module: SEC-DED checker and corrector.
// Assumes the check-bit layout of ecc_tm_encoder; combinational.
module ecc_tm_decoder
    import ecc_tm_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_single_o,
    output logic              err_double_o
);

    logic [HAM_W-1:0] syn;
    logic             par_odd;
    logic             hit;

    // Build syndrome and overall parity, then classify and repair.
    always_comb begin
        syn          = chk_i[HAM_W-1:0] ^ ham_bits(data_i);
        par_odd      = (^data_i) ^ (^chk_i);
        data_o       = data_i;
        hit          = 1'b0;
        err_single_o = 1'b0;
        err_double_o = 1'b0;
        for (int j = 0; j < DATA_W; j++) begin
            if (data_pos(j) == int'(syn)) begin
                data_o[j] = ~data_i[j];
                hit       = 1'b1;
            end
        end
        if (par_odd) begin
            if (syn == '0 || is_pow2(int'(syn)) || hit) begin
                err_single_o = 1'b1;
            end else begin
                err_double_o = 1'b1;
                data_o       = data_i;
            end
        end else begin
            data_o = data_i;
            if (syn != '0) err_double_o = 1'b1;
        end
    end

endmodule

// File: rtl/ecc_tm_ctrl.sv
// Module: control word holding one 2-bit test mode per bank.
// Assumes NUM_BANKS*2 <= 32; unused upper bits read as zero.
module ecc_tm_ctrl
    import ecc_tm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int REG_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [REG_W-1:0]              cfg_wdata,
    output logic [REG_W-1:0]              cfg_rdata,
    output logic [NUM_BANKS*MODE_W-1:0]   mode_vec_o
);

    localparam int FIELD_BITS = NUM_BANKS * MODE_W;

    logic [FIELD_BITS-1:0] mode_q;

    // Hold the mode fields; clear on reset, load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= '0;
        else if (cfg_we) mode_q <= cfg_wdata[FIELD_BITS-1:0];
    end

    // Zero-extend the fields onto the read bus.
    always_comb begin
        cfg_rdata                 = '0;
        cfg_rdata[FIELD_BITS-1:0] = mode_q;
    end

    assign mode_vec_o = mode_q;

    assert_cfg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[FIELD_BITS-1:0] == $past(cfg_wdata[FIELD_BITS-1:0]));

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

endmodule

// File: rtl/ecc_tm_bank.sv
// Module: one storage bank with separate data and check-bit arrays.
// The test mode gates which array a write updates; read is registered (1 cycle).
module ecc_tm_bank
    import ecc_tm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CHK_W-1:0]  enc_chk,
    input  logic [CHK_W-1:0]  wchk,
    output logic [DATA_W-1:0] raw_data_o,
    output logic [CHK_W-1:0]  raw_chk_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [CHK_W-1:0]  chk_mem  [DEPTH];
    logic              upd_data;
    logic              upd_chk;
    logic [CHK_W-1:0]  chk_src;
    logic [DATA_W-1:0] data_at_addr;
    logic [CHK_W-1:0]  chk_at_addr;

    // Decode the test mode into per-array write enables and check source.
    always_comb begin
        upd_data = wr_en && (mode != TM_CHK_ONLY);
        upd_chk  = wr_en && (mode != TM_DATA_ONLY);
        chk_src  = (mode == TM_CHK_ONLY) ? wchk : enc_chk;
    end

    // Data array write.
    always_ff @(posedge clk) begin
        if (upd_data) data_mem[addr] <= wdata;
    end

    // Check-bit array write.
    always_ff @(posedge clk) begin
        if (upd_chk) chk_mem[addr] <= chk_src;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_data_o <= '0;
            raw_chk_o  <= '0;
        end else if (rd_en) begin
            raw_data_o <= data_mem[addr];
            raw_chk_o  <= chk_mem[addr];
        end
    end

    assign data_at_addr = data_mem[addr];
    assign chk_at_addr  = chk_mem[addr];

    assert_data_only_keeps_chk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == TM_DATA_ONLY) |=> chk_mem[$past(addr)] == $past(chk_at_addr));

    assert_chk_only_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == TM_CHK_ONLY) |=> data_mem[$past(addr)] == $past(data_at_addr));

    assert_chk_only_takes_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == TM_CHK_ONLY) |=> chk_mem[$past(addr)] == $past(wchk));

endmodule

// File: rtl/ecc_tm_top.sv
// Module: four ECC-protected banks, a shared encoder and decoder, and the
// mode control word. Assumes one access per cycle across all banks.
module ecc_tm_top
    import ecc_tm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 4,
    parameter int REG_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [REG_W-1:0]             cfg_wdata,
    output logic [REG_W-1:0]             cfg_rdata,
    input  logic                         mem_req,
    input  logic                         mem_we,
    input  logic [$clog2(NUM_BANKS)-1:0] mem_bank,
    input  logic [ADDR_W-1:0]            mem_addr,
    input  logic [DATA_W-1:0]            mem_wdata,
    input  logic [CHK_W-1:0]             mem_wchk,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic [CHK_W-1:0]             rd_chk,
    output logic                         rd_err_single,
    output logic                         rd_err_double
);

    localparam int BANK_W = $clog2(NUM_BANKS);

    logic [NUM_BANKS*MODE_W-1:0] mode_vec;
    logic [CHK_W-1:0]            enc_chk;
    logic [DATA_W-1:0]           raw_data [NUM_BANKS];
    logic [CHK_W-1:0]            raw_chk  [NUM_BANKS];
    logic [BANK_W-1:0]           rd_bank_q;
    logic                        rd_valid_q;
    logic                        dec_single;
    logic                        dec_double;

    ecc_tm_ctrl #(.NUM_BANKS(NUM_BANKS), .REG_W(REG_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .mode_vec_o (mode_vec)
    );

    ecc_tm_encoder enc_i (
        .data_i (mem_wdata),
        .chk_o  (enc_chk)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = mem_req && (mem_bank == BANK_W'(b));
        ecc_tm_bank #(.ADDR_W(ADDR_W)) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (sel && mem_we),
            .rd_en      (sel && !mem_we),
            .addr       (mem_addr),
            .mode       (mode_vec[b*MODE_W +: MODE_W]),
            .wdata      (mem_wdata),
            .enc_chk    (enc_chk),
            .wchk       (mem_wchk),
            .raw_data_o (raw_data[b]),
            .raw_chk_o  (raw_chk[b])
        );
    end

    // Track which bank answers and whether a read is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_bank_q  <= '0;
        end else begin
            rd_valid_q <= mem_req && !mem_we;
            if (mem_req && !mem_we) rd_bank_q <= mem_bank;
        end
    end

    assign rd_chk = raw_chk[rd_bank_q];

    ecc_tm_decoder dec_i (
        .data_i       (raw_data[rd_bank_q]),
        .chk_i        (raw_chk[rd_bank_q]),
        .data_o       (rd_data),
        .err_single_o (dec_single),
        .err_double_o (dec_double)
    );

    // Qualify the error flags with the read-valid strobe.
    always_comb begin
        rd_valid      = rd_valid_q;
        rd_err_single = rd_valid_q && dec_single;
        rd_err_double = rd_valid_q && dec_double;
    end

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_err_single, rd_err_double}));

    assert_flags_need_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !(rd_err_single || rd_err_double));

    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> rd_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && !mem_we) |=> !rd_valid);

endmodule

// File: tb/ecc_tm_top_tb.sv
// Directed bench for ecc_tm_top: one task per scenario, each self-checking.
module ecc_tm_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req = 1'b0;
    logic        mem_we = 1'b0;
    logic [1:0]  mem_bank = '0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic [6:0]  mem_wchk = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [6:0]  rd_chk;
    logic        rd_err_single;
    logic        rd_err_double;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    ecc_tm_top #(.NUM_BANKS(4), .ADDR_W(ADDR_W), .REG_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wchk(mem_wchk),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
        .rd_err_single(rd_err_single), .rd_err_double(rd_err_double)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference code built from R7: lay out a 39-entry codeword, then parities.
    function automatic logic [6:0] ref_code(input logic [31:0] d);
        logic [38:0] cw;
        logic [6:0]  c;
        int k;
        cw = '0;
        k = 0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        c = '0;
        for (int i = 0; i < 6; i++)
            for (int p = 1; p <= 38; p++)
                if ((p >> i) & 1) c[i] = c[i] ^ cw[p];
        c[6] = (^d) ^ (^c[5:0]);
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mem_write(input logic [1:0] b, input logic [ADDR_W-1:0] a,
                             input logic [31:0] d, input logic [6:0] c);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_bank = b; mem_addr = a;
        mem_wdata = d; mem_wchk = c;
        @(posedge clk); #1;
        mem_req = 1'b0; mem_we = 1'b0;
        check("R10 no valid after write", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic mem_read(input logic [1:0] b, input logic [ADDR_W-1:0] a,
                            output logic [31:0] d, output logic [6:0] c,
                            output logic s, output logic dd);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b0; mem_bank = b; mem_addr = a;
        @(posedge clk); #1;
        mem_req = 1'b0;
        check("R10 valid one cycle after read", {63'd0, rd_valid}, 64'd1);
        d = rd_data; c = rd_chk; s = rd_err_single; dd = rd_err_double;
    endtask

    task automatic t_reset();
        check("R6 cfg_rdata after reset", {32'd0, cfg_rdata}, 64'd0);
        check("R6 rd_valid after reset", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic t_functional();
        logic [31:0] pats [4];
        logic [31:0] d; logic [6:0] c; logic s, dd;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h8000_0000;
        for (int i = 0; i < 4; i++) begin
            mem_write(2'd0, ADDR_W'(i), pats[i], 7'h55);
        end
        for (int i = 0; i < 4; i++) begin
            mem_read(2'd0, ADDR_W'(i), d, c, s, dd);
            check("R1 data", {32'd0, d}, {32'd0, pats[i]});
            check("R7 check bits", {57'd0, c}, {57'd0, ref_code(pats[i])});
            check("R1 flags clean", {62'd0, s, dd}, 64'd0);
        end
    endtask

    task automatic t_cfg();
        cfg_write(32'hFFFF_FFFF);
        check("R5 upper bits read zero", {32'd0, cfg_rdata}, 64'h0000_00FF);
        cfg_write(32'h1234_56E4);
        check("R5 field layout", {32'd0, cfg_rdata}, 64'h0000_00E4);
        cfg_write(32'h0);
    endtask

    task automatic t_data_only();
        logic [31:0] a; logic [31:0] d; logic [6:0] c; logic s, dd;
        a = 32'h1357_9BDF;
        mem_write(2'd1, 4'd3, a, '0);
        mem_write(2'd1, 4'd4, a, '0);
        cfg_write(32'h0000_0004);            // bank1 mode 01
        mem_write(2'd1, 4'd3, a ^ 32'h80, '0);
        mem_read(2'd1, 4'd3, d, c, s, dd);
        check("R2 check bits kept", {57'd0, c}, {57'd0, ref_code(a)});
        check("R8 data corrected", {32'd0, d}, {32'd0, a});
        check("R8 single flag", {62'd0, s, dd}, 64'd2);
        mem_write(2'd1, 4'd4, a ^ 32'h11, '0);
        mem_read(2'd1, 4'd4, d, c, s, dd);
        check("R9 double flag", {62'd0, s, dd}, 64'd1);
        // Bank0 stays functional while bank1 is in mode 01.
        mem_write(2'd0, 4'd7, 32'hCAFE_0001, '0);
        mem_read(2'd0, 4'd7, d, c, s, dd);
        check("R5 bank0 isolated chk", {57'd0, c}, {57'd0, ref_code(32'hCAFE_0001)});
        check("R5 bank0 isolated flags", {62'd0, s, dd}, 64'd0);
        cfg_write(32'h0);
    endtask

    task automatic t_chk_only();
        logic [31:0] x; logic [31:0] d; logic [6:0] c; logic s, dd;
        x = 32'h0F0F_3C3C;
        mem_write(2'd2, 4'd5, x, '0);
        cfg_write(32'h0000_0020);            // bank2 mode 10
        mem_write(2'd2, 4'd5, 32'hDEAD_BEEF, ref_code(x));
        mem_read(2'd2, 4'd5, d, c, s, dd);
        check("R3 data kept", {32'd0, d}, {32'd0, x});
        check("R3 flags clean", {62'd0, s, dd}, 64'd0);
        mem_write(2'd2, 4'd5, 32'h1111_1111, ref_code(x) ^ 7'h04);
        mem_read(2'd2, 4'd5, d, c, s, dd);
        check("R3 chk from port", {57'd0, c}, {57'd0, ref_code(x) ^ 7'h04});
        check("R8 chk error data ok", {32'd0, d}, {32'd0, x});
        check("R8 chk error single", {62'd0, s, dd}, 64'd2);
        mem_write(2'd2, 4'd5, 32'h2222_2222, ref_code(x) ^ 7'h40);
        mem_read(2'd2, 4'd5, d, c, s, dd);
        check("R8 overall bit single", {62'd0, s, dd}, 64'd2);
        check("R8 overall bit data", {32'd0, d}, {32'd0, x});
        mem_write(2'd2, 4'd5, 32'h3333_3333, ref_code(x) ^ 7'h03);
        mem_read(2'd2, 4'd5, d, c, s, dd);
        check("R9 two chk bits double", {62'd0, s, dd}, 64'd1);
        cfg_write(32'h0);
    endtask

    task automatic t_mode11();
        logic [31:0] w; logic [31:0] d; logic [6:0] c; logic s, dd;
        w = 32'h7654_3210;
        cfg_write(32'h0000_00C0);            // bank3 mode 11
        mem_write(2'd3, 4'd9, w, ~ref_code(w));
        mem_read(2'd3, 4'd9, d, c, s, dd);
        check("R4 data", {32'd0, d}, {32'd0, w});
        check("R4 chk from encoder", {57'd0, c}, {57'd0, ref_code(w)});
        check("R4 flags clean", {62'd0, s, dd}, 64'd0);
    endtask

    task automatic t_mid_reset();
        cfg_write(32'h0000_005A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R6 cfg cleared by reset", {32'd0, cfg_rdata}, 64'd0);
        check("R6 rd_valid low after reset", {63'd0, rd_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_functional();
        t_cfg();
        t_data_only();
        t_chk_only();
        t_mode11();
        t_mid_reset();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule